// File: doc/BRIEF.md
# Completion-Queue Level Interrupt Aggregator

This block drives the single level-sensitive interrupt pin of a storage controller that runs many completion queues. It holds one pending bit for each queue identifier. A pending bit is set when a completion is posted to a queue whose interrupt enable is on. It is cleared when the consumer writes that queue's head doorbell and the new head equals the tail.

A 32-bit mask register is written through two offsets. One offset sets mask bits and the other clears them. Both offsets read back the same current mask. Pending bits for queues 32 and above are never masked.

The pin is a registered level. It stays high while any unmasked queue has unconsumed completions, and it does not pulse once per completion. While message-signalled delivery is enabled, the pin is held low and queue events leave the pending state alone. Mask writes still take effect during that time.

Top module: `cq_legacy_irq`

## Requirements
- R1: After reset, `irq_o` is 0, every pending bit is clear and the mask is 0, so a read at either mask offset returns 0.
- R2: A completion event (`post_vld`, `post_qid`) for a queue whose bit in `cq_irq_en` is 1 sets that queue's pending bit, while `msi_en` is 0.
- R3: A head-doorbell event (`db_vld`, `db_qid`) for an enabled queue clears its pending bit only when `db_head` equals `db_tail`. When head differs from tail, the event has no effect.
- R4: Neither a completion event nor a doorbell event changes the pending bit of a queue whose bit in `cq_irq_en` is 0.
- R5: The pin level is the OR over all queues of pending AND NOT mask. The mask bit with index q covers queue q for q below 32. Queues 32 to 63 are always unmasked.
- R6: A write at offset 0x0C ORs `reg_wr_data` into the mask. A write at offset 0x10 clears the mask bits that are 1 in `reg_wr_data`. A write at any other offset leaves the mask unchanged.
- R7: A read at offset 0x0C or at offset 0x10 returns the current mask on `reg_rd_data`, combinationally. A read at any other offset returns 0.
- R8: While `msi_en` is 1, `irq_o` is 0 from the next clock on, and completion and doorbell events do not change pending bits. Mask writes still apply. Once `msi_en` returns to 0, the pin reflects the held state one clock later.
- R9: If a completion event and a clearing doorbell event hit the same enabled queue in the same cycle, the pending bit ends up set.
- R10: `irq_o` is registered. It takes the level that results from the events and mask writes of a cycle on the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msi_en | input | 1 | Message-signalled delivery active; pin held low |
| cq_irq_en | input | 64 | Per-queue interrupt enable flags |
| post_vld | input | 1 | Completion posted this cycle |
| post_qid | input | 6 | Queue receiving the completion |
| db_vld | input | 1 | Head doorbell written this cycle |
| db_qid | input | 6 | Queue whose head doorbell was written |
| db_head | input | 16 | New head pointer |
| db_tail | input | 16 | Current tail pointer of that queue |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 5 | Register write byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 5 | Register read byte offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Level interrupt pin |

## Verification
Pending bits and the mask update on the rising edge that samples an event or a write. The pin is registered from those next-state values, so its new level is due one edge after the stimulus. The read data is combinational from the mask register, so it shows a write after that same edge.

The bench drives every input on the falling edge. It samples one time unit after the following rising edge, updates its own model of pending bits and mask at that point, and compares both the pin and the read data there. Lasting effects, such as an event ignored while a queue is disabled, are also checked on later cycles after the enables or modes are restored.

// File: rtl/cqia_pkg.sv
// Package: shared constants for the completion-queue level interrupt block.
// Assumes byte offsets fit in the register address width used by the top.
package cqia_pkg;
    localparam int unsigned OFS_W       = 5;
    localparam logic [OFS_W-1:0] OFS_MASK_SET = 5'h0C;
    localparam logic [OFS_W-1:0] OFS_MASK_CLR = 5'h10;

    typedef enum logic [1:0] {
        MW_NONE = 2'd0,
        MW_SET  = 2'd1,
        MW_CLR  = 2'd2
    } mask_op_e;
endpackage

// File: rtl/cqia_mask_reg.sv
// Module: cqia_mask_reg
// Holds the interrupt mask. One write offset sets bits, another clears them,
// and both offsets read back the same register. Exposes the next-state value
// so the pin stage can register the level in the same edge.
// Assumes write data width equals the mask width.
module cqia_mask_reg
    import cqia_pkg::*;
#(
    parameter int unsigned MASK_W = 32,
    parameter int unsigned ADDR_W = OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [MASK_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [MASK_W-1:0] rd_data,
    output logic [MASK_W-1:0] mask_q,
    output logic [MASK_W-1:0] mask_d
);
    mask_op_e op;

    // Decode the write offset into a mask operation.
    always_comb begin
        op = MW_NONE;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(OFS_MASK_SET))      op = MW_SET;
            else if (wr_addr == ADDR_W'(OFS_MASK_CLR)) op = MW_CLR;
        end
    end

    // Compute the next mask value from the operation.
    always_comb begin
        unique case (op)
            MW_SET:  mask_d = mask_q | wr_data;
            MW_CLR:  mask_d = mask_q & ~wr_data;
            default: mask_d = mask_q;
        endcase
    end

    // Store the mask; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    // Both mask offsets read the same value; others read zero.
    always_comb begin
        if (rd_addr == ADDR_W'(OFS_MASK_SET) || rd_addr == ADDR_W'(OFS_MASK_CLR))
            rd_data = mask_q;
        else
            rd_data = '0;
    end
endmodule

// File: rtl/cqia_pending.sv
// Module: cqia_pending
// One pending bit per completion queue. A posted completion sets the bit and
// a doorbell with head equal to tail clears it; both require the queue's
// interrupt enable, and neither acts while message-signalled delivery is on.
// A set and a clear for one queue in one cycle leave the bit set.
module cqia_pending #(
    parameter int unsigned NUM_CQ = 64,
    parameter int unsigned PTR_W  = 16,
    localparam int unsigned QID_W = $clog2(NUM_CQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msi_en,
    input  logic [NUM_CQ-1:0] cq_irq_en,
    input  logic              post_vld,
    input  logic [QID_W-1:0]  post_qid,
    input  logic              db_vld,
    input  logic [QID_W-1:0]  db_qid,
    input  logic [PTR_W-1:0]  db_head,
    input  logic [PTR_W-1:0]  db_tail,
    output logic [NUM_CQ-1:0] pend_q,
    output logic [NUM_CQ-1:0] pend_d
);
    logic post_ok;
    logic clr_ok;

    // Qualify events that may touch pending state at all.
    always_comb begin
        post_ok = post_vld && !msi_en;
        clr_ok  = db_vld && !msi_en && (db_head == db_tail);
    end

    for (genvar q = 0; q < NUM_CQ; q++) begin : g_cq
        logic hit_set;
        logic hit_clr;

        // Per-queue next state with set taking priority over clear.
        always_comb begin
            hit_set   = post_ok && (post_qid == QID_W'(q)) && cq_irq_en[q];
            hit_clr   = clr_ok  && (db_qid   == QID_W'(q)) && cq_irq_en[q];
            pend_d[q] = hit_set ? 1'b1 : (hit_clr ? 1'b0 : pend_q[q]);
        end
    end

    // Store the pending vector; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/cqia_level.sv
// Module: cqia_level
// Registers the interrupt pin from the next-state pending and mask vectors.
// Queues at or above the mask width are never masked. The pin is held low
// while message-signalled delivery is enabled.
// Assumes NUM_CQ is larger than MASK_W.
module cqia_level #(
    parameter int unsigned NUM_CQ = 64,
    parameter int unsigned MASK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msi_en,
    input  logic [NUM_CQ-1:0] pend_d,
    input  logic [MASK_W-1:0] mask_d,
    output logic              irq_q
);
    localparam int unsigned HI_W = NUM_CQ - MASK_W;

    logic [NUM_CQ-1:0] mask_ext;
    logic              level;

    // Widen the mask with zeros so upper queues stay unmasked.
    always_comb begin
        mask_ext = {{HI_W{1'b0}}, mask_d};
        level    = |(pend_d & ~mask_ext);
    end

    // Register the pin, forcing it low under message-signalled delivery.
    always_ff @(posedge clk) begin
        if (!rst_n)      irq_q <= 1'b0;
        else if (msi_en) irq_q <= 1'b0;
        else             irq_q <= level;
    end
endmodule

// File: rtl/cq_legacy_irq.sv
// Module: cq_legacy_irq
// Top of the completion-queue level interrupt aggregator: mask register,
// per-queue pending tracker and registered pin stage.
// Assumes queue identifiers are below NUM_CQ and at most one completion and
// one doorbell event arrive per cycle.
module cq_legacy_irq
    import cqia_pkg::*;
#(
    parameter int unsigned NUM_CQ = 64,
    parameter int unsigned MASK_W = 32,
    parameter int unsigned PTR_W  = 16,
    parameter int unsigned ADDR_W = OFS_W,
    localparam int unsigned QID_W = $clog2(NUM_CQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msi_en,
    input  logic [NUM_CQ-1:0] cq_irq_en,
    input  logic              post_vld,
    input  logic [QID_W-1:0]  post_qid,
    input  logic              db_vld,
    input  logic [QID_W-1:0]  db_qid,
    input  logic [PTR_W-1:0]  db_head,
    input  logic [PTR_W-1:0]  db_tail,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [MASK_W-1:0] reg_wr_data,
    input  logic [ADDR_W-1:0] reg_rd_addr,
    output logic [MASK_W-1:0] reg_rd_data,
    output logic              irq_o
);
    logic [MASK_W-1:0] mask_q;
    logic [MASK_W-1:0] mask_d;
    logic [NUM_CQ-1:0] pend_q;
    logic [NUM_CQ-1:0] pend_d;

    cqia_mask_reg #(.MASK_W(MASK_W), .ADDR_W(ADDR_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_wr_addr),
        .wr_data (reg_wr_data),
        .rd_addr (reg_rd_addr),
        .rd_data (reg_rd_data),
        .mask_q  (mask_q),
        .mask_d  (mask_d)
    );

    cqia_pending #(.NUM_CQ(NUM_CQ), .PTR_W(PTR_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .msi_en    (msi_en),
        .cq_irq_en (cq_irq_en),
        .post_vld  (post_vld),
        .post_qid  (post_qid),
        .db_vld    (db_vld),
        .db_qid    (db_qid),
        .db_head   (db_head),
        .db_tail   (db_tail),
        .pend_q    (pend_q),
        .pend_d    (pend_d)
    );

    cqia_level #(.NUM_CQ(NUM_CQ), .MASK_W(MASK_W)) u_level (
        .clk    (clk),
        .rst_n  (rst_n),
        .msi_en (msi_en),
        .pend_d (pend_d),
        .mask_d (mask_d),
        .irq_q  (irq_o)
    );
endmodule

// File: rtl/cq_legacy_irq_checker.sv
// Module: cq_legacy_irq_checker
// Timing properties of the aggregator, bound to the top. Relates the pin to
// the stored pending and mask state, and event inputs to the state after.
module cq_legacy_irq_checker
    import cqia_pkg::*;
#(
    parameter int unsigned NUM_CQ = 64,
    parameter int unsigned MASK_W = 32,
    parameter int unsigned PTR_W  = 16,
    parameter int unsigned ADDR_W = OFS_W,
    localparam int unsigned QID_W = $clog2(NUM_CQ)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              msi_en,
    input logic [NUM_CQ-1:0] cq_irq_en,
    input logic              post_vld,
    input logic [QID_W-1:0]  post_qid,
    input logic              db_vld,
    input logic [QID_W-1:0]  db_qid,
    input logic [PTR_W-1:0]  db_head,
    input logic [PTR_W-1:0]  db_tail,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_wr_addr,
    input logic [MASK_W-1:0] reg_wr_data,
    input logic              irq_o,
    input logic [NUM_CQ-1:0] pend_q,
    input logic [MASK_W-1:0] mask_q
);
    logic past_ok;

    // Marks that one clock has passed since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r8_msi_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        msi_en |=> !irq_o);

    a_r5_pin_matches_state: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(msi_en)) |->
        (irq_o == |(pend_q & ~{{(NUM_CQ-MASK_W){1'b0}}, mask_q})));

    a_r4_disabled_queue_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (post_vld && !cq_irq_en[post_qid]) |=>
        (pend_q[$past(post_qid)] == $past(pend_q[post_qid])));

    a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (post_vld && db_vld && post_qid == db_qid && cq_irq_en[post_qid] && !msi_en)
        |=> pend_q[$past(post_qid)]);

    a_r3_doorbell_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (db_vld && cq_irq_en[db_qid] && !msi_en && db_head == db_tail &&
         !(post_vld && post_qid == db_qid)) |=> !pend_q[$past(db_qid)]);

    a_r6_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_addr == ADDR_W'(OFS_MASK_SET)) |=>
        (mask_q == ($past(mask_q) | $past(reg_wr_data))));

    a_r6_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_addr == ADDR_W'(OFS_MASK_CLR)) |=>
        (mask_q == ($past(mask_q) & ~$past(reg_wr_data))));
endmodule

bind cq_legacy_irq cq_legacy_irq_checker #(
    .NUM_CQ(NUM_CQ), .MASK_W(MASK_W), .PTR_W(PTR_W), .ADDR_W(ADDR_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .cq_irq_en(cq_irq_en),
    .post_vld(post_vld), .post_qid(post_qid), .db_vld(db_vld), .db_qid(db_qid),
    .db_head(db_head), .db_tail(db_tail), .reg_wr_en(reg_wr_en),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data), .irq_o(irq_o),
    .pend_q(pend_q), .mask_q(mask_q)
);

// File: tb/cq_legacy_irq_tb_top.sv
// Bench for cq_legacy_irq: directed corner cases and seeded random traffic,
// checked against a bench model of pending bits and mask.
module cq_legacy_irq_tb_top;
    localparam int NQ = 64;
    localparam int MW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          msi_en = 1'b0;
    logic [NQ-1:0] cq_irq_en = '0;
    logic          post_vld = 1'b0;
    logic [5:0]    post_qid = '0;
    logic          db_vld = 1'b0;
    logic [5:0]    db_qid = '0;
    logic [15:0]   db_head = '0;
    logic [15:0]   db_tail = '0;
    logic          reg_wr_en = 1'b0;
    logic [4:0]    reg_wr_addr = '0;
    logic [MW-1:0] reg_wr_data = '0;
    logic [4:0]    reg_rd_addr = 5'h0C;
    logic [MW-1:0] reg_rd_data;
    logic          irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    logic [NQ-1:0] m_pend = '0;
    logic [MW-1:0] m_mask = '0;
    logic          m_irq  = 1'b0;

    always #2 clk = ~clk;

    cq_legacy_irq dut_i (
        .clk(clk), .rst_n(rst_n), .msi_en(msi_en), .cq_irq_en(cq_irq_en),
        .post_vld(post_vld), .post_qid(post_qid), .db_vld(db_vld), .db_qid(db_qid),
        .db_head(db_head), .db_tail(db_tail), .reg_wr_en(reg_wr_en),
        .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data), .irq_o(irq_o)
    );

    function automatic logic f_level(logic [NQ-1:0] p, logic [MW-1:0] m, logic msi);
        return !msi && (|(p & ~{{(NQ-MW){1'b0}}, m}));
    endfunction

    function automatic logic [MW-1:0] f_read(logic [4:0] a, logic [MW-1:0] m);
        return (a == 5'h0C || a == 5'h10) ? m : '0;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Advance the model by the inputs held across the last rising edge.
    task automatic model_update();
        logic [NQ-1:0] nxt;
        nxt = m_pend;
        if (!msi_en && db_vld && cq_irq_en[db_qid] && db_head == db_tail) nxt[db_qid] = 1'b0;
        if (!msi_en && post_vld && cq_irq_en[post_qid]) nxt[post_qid] = 1'b1;
        m_pend = nxt;
        if (reg_wr_en && reg_wr_addr == 5'h0C) m_mask = m_mask | reg_wr_data;
        else if (reg_wr_en && reg_wr_addr == 5'h10) m_mask = m_mask & ~reg_wr_data;
        m_irq = f_level(m_pend, m_mask, msi_en);
    endtask

    // Drive one cycle at the falling edge, then check after the rising edge.
    task automatic step(string req, logic pv, logic [5:0] pq, logic dv, logic [5:0] dq,
                        logic [15:0] h, logic [15:0] t, logic wv, logic [4:0] wa,
                        logic [MW-1:0] wd, logic msi, logic [4:0] ra);
        @(negedge clk);
        post_vld = pv; post_qid = pq; db_vld = dv; db_qid = dq;
        db_head = h; db_tail = t; reg_wr_en = wv; reg_wr_addr = wa;
        reg_wr_data = wd; msi_en = msi; reg_rd_addr = ra;
        @(posedge clk);
        #1;
        model_update();
        chk(req, {63'd0, irq_o}, {63'd0, m_irq});
        chk("R7", {32'd0, reg_rd_data}, {32'd0, f_read(ra, m_mask)});
    endtask

    task automatic idle(string req);
        step(req, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 5'h10);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", {63'd0, irq_o}, 64'd0);
        chk("R1", {32'd0, reg_rd_data}, 64'd0);
        cq_irq_en = '1;
        idle("R1");

        // R2 and R10: post to queue 5 raises the pin one edge later
        step("R2", 1, 6'd5, 0, 0, 0, 0, 0, 0, 0, 0, 5'h0C);
        // R6: masking queue 5 drops the pin, unmasking raises it
        step("R6", 0, 0, 0, 0, 0, 0, 1, 5'h0C, 32'h20, 0, 5'h0C);
        chk("R10", {63'd0, irq_o}, 64'd0);
        step("R6", 0, 0, 0, 0, 0, 0, 1, 5'h10, 32'h20, 0, 5'h10);
        // R3: head behind tail keeps it, head at tail clears it
        step("R3", 0, 0, 1, 6'd5, 16'd3, 16'd4, 0, 0, 0, 0, 5'h0C);
        chk("R3", {63'd0, irq_o}, 64'd1);
        step("R3", 0, 0, 1, 6'd5, 16'd4, 16'd4, 0, 0, 0, 0, 5'h0C);
        chk("R3", {63'd0, irq_o}, 64'd0);

        // R5: queue 40 ignores a full mask
        step("R5", 1, 6'd40, 0, 0, 0, 0, 1, 5'h0C, 32'hFFFF_FFFF, 0, 5'h0C);
        chk("R5", {63'd0, irq_o}, 64'd1);
        step("R5", 0, 0, 1, 6'd40, 16'd9, 16'd9, 1, 5'h10, 32'hFFFF_FFFF, 0, 5'h10);
        chk("R5", {63'd0, irq_o}, 64'd0);

        // R9: same-cycle post and clearing doorbell leave queue 7 pending
        step("R9", 1, 6'd7, 1, 6'd7, 16'd2, 16'd2, 0, 0, 0, 0, 5'h0C);
        chk("R9", {63'd0, irq_o}, 64'd1);
        step("R3", 0, 0, 1, 6'd7, 16'd2, 16'd2, 0, 0, 0, 0, 5'h0C);

        // R4: disabled queue 9 ignores a post, even after re-enable
        cq_irq_en[9] = 1'b0;
        step("R4", 1, 6'd9, 0, 0, 0, 0, 0, 0, 0, 0, 5'h0C);
        chk("R4", {63'd0, irq_o}, 64'd0);
        cq_irq_en[9] = 1'b1;
        idle("R4");
        chk("R4", {63'd0, irq_o}, 64'd0);
        // R4: disabled queue ignores a clearing doorbell
        step("R4", 1, 6'd9, 0, 0, 0, 0, 0, 0, 0, 0, 5'h0C);
        cq_irq_en[9] = 1'b0;
        step("R4", 0, 0, 1, 6'd9, 16'd1, 16'd1, 0, 0, 0, 0, 5'h0C);
        chk("R4", {63'd0, irq_o}, 64'd1);
        cq_irq_en[9] = 1'b1;
        step("R3", 0, 0, 1, 6'd9, 16'd1, 16'd1, 0, 0, 0, 0, 5'h0C);

        // R8: events ignored and pin low under message-signalled delivery
        step("R8", 1, 6'd3, 0, 0, 0, 0, 0, 0, 0, 1, 5'h0C);
        idle("R8");
        chk("R8", {63'd0, irq_o}, 64'd0);
        step("R8", 1, 6'd3, 0, 0, 0, 0, 0, 0, 0, 0, 5'h0C);
        step("R8", 0, 0, 0, 0, 0, 0, 1, 5'h0C, 32'h1, 1, 5'h0C);
        chk("R8", {63'd0, irq_o}, 64'd0);
        idle("R8");
        chk("R8", {63'd0, irq_o}, 64'd1);
        step("R3", 0, 0, 1, 6'd3, 16'd0, 16'd0, 1, 5'h10, 32'h1, 0, 5'h10);

        // R6: write to an unused offset leaves the mask alone
        step("R6", 0, 0, 0, 0, 0, 0, 1, 5'h08, 32'hFFFF_FFFF, 0, 5'h0C);
        chk("R6", {32'd0, reg_rd_data}, 64'd0);
        step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 5'h08);

        // Random traffic: R2 R3 R4 R5 R6 R7 R8 R9 against the model
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] wa;
            logic [4:0] ra;
            logic [15:0] h;
            int sel;
            if ((i % 200) == 0) cq_irq_en = {$urandom, $urandom} | {$urandom, $urandom};
            sel = $urandom_range(0, 2);
            wa = (sel == 0) ? 5'h0C : (sel == 1) ? 5'h10 : 5'h14;
            sel = $urandom_range(0, 2);
            ra = (sel == 0) ? 5'h0C : (sel == 1) ? 5'h10 : 5'h04;
            h = 16'($urandom_range(0, 3));
            step("R5", ($urandom_range(0, 2) == 0), 6'($urandom_range(0, 63)),
                 ($urandom_range(0, 1) == 0), 6'($urandom_range(0, 63)),
                 h, 16'($urandom_range(0, 1)) + h * 16'($urandom_range(0, 1)),
                 ($urandom_range(0, 5) == 0), wa, $urandom & $urandom,
                 ($urandom_range(0, 15) == 0), ra);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule